// File: doc/BRIEF.md
# Power-on and System Reset Sequencer

This block orders the reset of a small system-on-chip from a free-running reference clock. An active-low power-on pin, a watchdog reset event and a software reset request are its three causes. Only the power-on cause captures the strap inputs, puts the phase-locked loops into reset and then opens their clock outputs one after another, each one after it reports lock, with the last loop always opened last. It also holds the CPU in reset for a long fixed interval and gives the timer registers a one-cycle clear.

The watchdog and software causes act only on the shared PCI/LPC bus reset and on the CPU reset. They leave the straps and the loops alone. The bus reset lasts a minimum number of cycles, and the CPU comes out of reset a fixed number of cycles after the bus does. A done flag tells the rest of the chip when every output is open and every reset has been released.

Top module: `reset_sequencer`

## Requirements
- R1: `strap_q` loads `strap_in` on every clock edge at which the internal power-on state is active. It holds its value while that state is inactive, whatever the watchdog or software inputs do.
- R2: While the internal power-on state is active, every bit of `pll_rst` is 1 and every bit of `pll_oe` is 0. The internal power-on state ends at the second rising clock edge after `por_n` goes high, and `pll_rst` falls to all zeros at that edge.
- R3: Bit 0 of `pll_oe` rises at the first edge, after the power-on state ends, at which `pll_lock[0]` is 1. Bit i>0 rises at the first edge at which both `pll_lock[i]` and `pll_oe[i-1]` are 1, so a lock that arrives early waits for its turn and the highest bit is always the last to rise. Once set, a bit stays at 1 until the next power-on reset, even if its lock falls.
- R4: After a power-on reset, with no other cause present, `cpu_rst` stays at 1 for exactly CPU_HOLD_CYCLES clock cycles after the internal power-on state ends.
- R5: `bus_rst_n` is 0 while the internal power-on state is active and goes to 1 at the same edge at which `pll_rst` is released.
- R6: When `wdt_rst_evt` or `sw_rst_req` is 1 at an edge outside the power-on state, `bus_rst_n` is 0 from that edge onward. It returns to 1 SYS_MIN_CYCLES edges after the last edge at which either input was 1. `pll_rst`, `pll_oe` and `strap_q` do not change.
- R7: `cpu_rst` is 1 whenever `bus_rst_n` is 0. After a watchdog or software reset it stays at 1 for CPU_TAIL_CYCLES cycles after `bus_rst_n` rises. If more of a power-on hold remains than that, the longer time applies.
- R8: `tmr_clr` is 1 for exactly one cycle, the cycle right after the internal power-on state ends. At all other times it is 0.
- R9: `seq_done` is 1 one edge after every `pll_oe` bit is 1, `bus_rst_n` is 1 and `cpu_rst` is 0. It falls one edge after any of these conditions stops holding, and at once when `por_n` goes low.
- R10: `wdt_rst_evt` and `sw_rst_req` have no effect during the power-on state. They do not lengthen the bus reset or the CPU reset after the power-on state ends.
- R11: `por_n` going low sets `pll_rst` to all ones, `pll_oe` to zero, `bus_rst_n` to 0 and `cpu_rst` to 1 at once, without waiting for a clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Free-running reference clock |
| por_n | input | 1 | Active-low power-on reset pin (asynchronous) |
| wdt_rst_evt | input | 1 | Watchdog reset event, active high |
| sw_rst_req | input | 1 | Software system reset request, active high |
| pll_lock | input | NUM_PLL | Lock indication from each PLL |
| strap_in | input | STRAP_W | Strap pin values |
| strap_q | output | STRAP_W | Latched strap values |
| pll_rst | output | NUM_PLL | Reset to each PLL, active high |
| pll_oe | output | NUM_PLL | Clock output enable for each PLL |
| cpu_rst | output | 1 | CPU reset, active high |
| bus_rst_n | output | 1 | PCI/LPC bus reset, active low |
| tmr_clr | output | 1 | One-cycle clear for the timer register bits |
| seq_done | output | 1 | All outputs enabled and all resets released |

## Verification
The hardest cases to reach from the ports are a power-on pin that falls in the middle of a clock cycle, after the sequence is partly done, and a system reset that lands while part of a power-on CPU hold is still counting. The stimulus drives short power-on pulses of random length and lock bits that arrive early, in reverse order, or that fall after their enable. It also fires watchdog and software pulses, including during the power-on state, and drops `por_n` between clock edges several times so that the asynchronous path and the restart can be seen. A cycle model in the bench, built from the requirements, predicts every output at every falling edge.

// File: rtl/rstseq_pkg.sv
package rstseq_pkg;

  // Bits needed to hold values 0..maxval
  function automatic int cnt_bits(input int maxval);
    if (maxval < 2) return 1;
    return $clog2(maxval + 1);
  endfunction

  function automatic int max_of(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/rstseq_por_sync.sv
module rstseq_por_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic por_n,
  output logic por_active,
  output logic tmr_clr
);
  logic [STAGES-1:0] sync_q;
  logic              active_d;

  // Asynchronous entry, synchronous exit
  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) sync_q <= '0;
    else        sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign por_active = ~sync_q[STAGES-1];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) active_d <= 1'b1;
    else        active_d <= por_active;
  end

  // One cycle after the power-on state ends
  assign tmr_clr = active_d & ~por_active;

  assert_clr_single_R8: assert property (@(posedge clk) disable iff (por_active)
    tmr_clr |=> !tmr_clr);
endmodule

// File: rtl/rstseq_strap_latch.sv
module rstseq_strap_latch #(
  parameter int WIDTH = 8
) (
  input  logic             clk,
  input  logic             hold,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  always_ff @(posedge clk) begin
    if (hold) q <= d;
  end

  assert_strap_frozen_R1: assert property (@(posedge clk) disable iff (hold)
    !$past(hold) |-> $stable(q));
endmodule

// File: rtl/rstseq_pll_chain.sv
module rstseq_pll_chain #(
  parameter int NUM_PLL = 3
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               hold,
  input  logic [NUM_PLL-1:0] lock,
  output logic [NUM_PLL-1:0] pll_rst,
  output logic [NUM_PLL-1:0] oe
);
  assign pll_rst = {NUM_PLL{hold}};

  for (genvar i = 0; i < NUM_PLL; i++) begin : g_stage
    logic turn;
    logic en_q;

    if (i == 0) begin : g_first
      assign turn = 1'b1;
    end else begin : g_next
      assign turn = oe[i-1];
    end

    // Sticky enable: opens on lock when the previous stage is already open
    always_ff @(posedge clk or negedge por_n) begin
      if (!por_n)               en_q <= 1'b0;
      else if (hold)            en_q <= 1'b0;
      else if (lock[i] && turn) en_q <= 1'b1;
    end

    assign oe[i] = en_q;

    assert_order_R3: assert property (@(posedge clk) disable iff (hold)
      $rose(en_q) |-> ($past(lock[i]) && $past(turn)));
  end
endmodule

// File: rtl/rstseq_reset_timer.sv
module rstseq_reset_timer
  import rstseq_pkg::*;
#(
  parameter int SYS_MIN_CYCLES  = 16,
  parameter int CPU_HOLD_CYCLES = 3300,
  parameter int CPU_TAIL_CYCLES = 8
) (
  input  logic clk,
  input  logic por_n,
  input  logic hold,
  input  logic sys_evt,
  output logic sys_active,
  output logic cpu_rst
);
  localparam int SW = cnt_bits(SYS_MIN_CYCLES);
  localparam int CW = cnt_bits(max_of(CPU_HOLD_CYCLES, CPU_TAIL_CYCLES));
  localparam logic [SW-1:0] SYS_V  = SW'(SYS_MIN_CYCLES);
  localparam logic [CW-1:0] HOLD_V = CW'(CPU_HOLD_CYCLES);
  localparam logic [CW-1:0] TAIL_V = CW'(CPU_TAIL_CYCLES);

  logic [SW-1:0] sys_cnt;
  logic [CW-1:0] cpu_cnt;

  // During a system reset the CPU counter keeps the longer of its
  // remaining hold and the tail length
  function automatic logic [CW-1:0] during_sys(input logic [CW-1:0] c);
    return (c > TAIL_V) ? c : TAIL_V;
  endfunction

  function automatic logic [CW-1:0] count_down(input logic [CW-1:0] c);
    return (c != '0) ? c - 1'b1 : c;
  endfunction

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)               sys_cnt <= '0;
    else if (hold)            sys_cnt <= '0;
    else if (sys_evt)         sys_cnt <= SYS_V;
    else if (sys_cnt != '0)   sys_cnt <= sys_cnt - 1'b1;
  end

  assign sys_active = (sys_cnt != '0);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n)          cpu_cnt <= HOLD_V;
    else if (hold)       cpu_cnt <= HOLD_V;
    else if (sys_active) cpu_cnt <= during_sys(cpu_cnt);
    else                 cpu_cnt <= count_down(cpu_cnt);
  end

  assign cpu_rst = hold | sys_active | (cpu_cnt != '0);

  assert_sys_len_R6: assert property (@(posedge clk) disable iff (hold)
    $rose(sys_active) |-> (sys_cnt == SYS_V));

  assert_cpu_tail_R7: assert property (@(posedge clk) disable iff (hold)
    $fell(sys_active) |-> (cpu_cnt >= TAIL_V));
endmodule

// File: rtl/reset_sequencer.sv
module reset_sequencer #(
  parameter int NUM_PLL         = 3,
  parameter int STRAP_W         = 8,
  parameter int SYNC_STAGES     = 2,
  parameter int SYS_MIN_CYCLES  = 16,
  parameter int CPU_HOLD_CYCLES = 3300,
  parameter int CPU_TAIL_CYCLES = 8
) (
  input  logic               clk,
  input  logic               por_n,
  input  logic               wdt_rst_evt,
  input  logic               sw_rst_req,
  input  logic [NUM_PLL-1:0] pll_lock,
  input  logic [STRAP_W-1:0] strap_in,
  output logic [STRAP_W-1:0] strap_q,
  output logic [NUM_PLL-1:0] pll_rst,
  output logic [NUM_PLL-1:0] pll_oe,
  output logic               cpu_rst,
  output logic               bus_rst_n,
  output logic               tmr_clr,
  output logic               seq_done
);
  logic por_active;
  logic sys_evt;
  logic sys_active;
  logic done_q;

  assign sys_evt = wdt_rst_evt | sw_rst_req;

  rstseq_por_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk        (clk),
    .por_n      (por_n),
    .por_active (por_active),
    .tmr_clr    (tmr_clr)
  );

  rstseq_strap_latch #(.WIDTH(STRAP_W)) u_strap (
    .clk  (clk),
    .hold (por_active),
    .d    (strap_in),
    .q    (strap_q)
  );

  rstseq_pll_chain #(.NUM_PLL(NUM_PLL)) u_pll (
    .clk     (clk),
    .por_n   (por_n),
    .hold    (por_active),
    .lock    (pll_lock),
    .pll_rst (pll_rst),
    .oe      (pll_oe)
  );

  rstseq_reset_timer #(
    .SYS_MIN_CYCLES  (SYS_MIN_CYCLES),
    .CPU_HOLD_CYCLES (CPU_HOLD_CYCLES),
    .CPU_TAIL_CYCLES (CPU_TAIL_CYCLES)
  ) u_timer (
    .clk        (clk),
    .por_n      (por_n),
    .hold       (por_active),
    .sys_evt    (sys_evt),
    .sys_active (sys_active),
    .cpu_rst    (cpu_rst)
  );

  assign bus_rst_n = ~(por_active | sys_active);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) done_q <= 1'b0;
    else        done_q <= (&pll_oe) & bus_rst_n & ~cpu_rst;
  end

  assign seq_done = done_q;

  assert_sys_bus_R6: assert property (@(posedge clk) disable iff (por_active)
    sys_evt |=> !bus_rst_n);

  assert_bus_cpu_R7: assert property (@(posedge clk) disable iff (por_active)
    !bus_rst_n |-> cpu_rst);

  assert_done_R9: assert property (@(posedge clk) disable iff (por_active)
    seq_done |-> $past((&pll_oe) && bus_rst_n && !cpu_rst));
endmodule

// File: tb/reset_sequencer_test.sv
`timescale 1ns/1ps
module reset_sequencer_test;
  localparam int N    = 3;
  localparam int SW   = 8;
  localparam int SYS  = 6;
  localparam int HOLD = 40;
  localparam int TAIL = 5;

  logic          clk = 1'b0;
  logic          por_n;
  logic          wdt_rst_evt, sw_rst_req;
  logic [N-1:0]  pll_lock;
  logic [SW-1:0] strap_in;
  logic [SW-1:0] strap_q;
  logic [N-1:0]  pll_rst, pll_oe;
  logic          cpu_rst, bus_rst_n, tmr_clr, seq_done;

  reset_sequencer #(
    .NUM_PLL(N), .STRAP_W(SW), .SYNC_STAGES(2),
    .SYS_MIN_CYCLES(SYS), .CPU_HOLD_CYCLES(HOLD), .CPU_TAIL_CYCLES(TAIL)
  ) uut (
    .clk(clk), .por_n(por_n), .wdt_rst_evt(wdt_rst_evt), .sw_rst_req(sw_rst_req),
    .pll_lock(pll_lock), .strap_in(strap_in), .strap_q(strap_q),
    .pll_rst(pll_rst), .pll_oe(pll_oe), .cpu_rst(cpu_rst),
    .bus_rst_n(bus_rst_n), .tmr_clr(tmr_clr), .seq_done(seq_done)
  );

  always #5 clk = ~clk;

  int  errors = 0;
  int  checks = 0;
  int  cycles = 0;
  bit  chk_on = 1'b0;
  bit  ended  = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  // ---------------- bench model, written from the requirements ----------------
  int           rel;        // clock edges since por_n went high (saturates at 3)
  int           sys_left;
  int           cpu_left;
  logic [N-1:0] oe_m;
  logic         done_m;
  logic [SW-1:0] strap_m;

  function automatic bit m_por(input int r);      // internal power-on state (R2)
    return r < 2;
  endfunction
  function automatic int m_cpu_sys(input int left); // R7: the longer time wins
    return (left > TAIL) ? left : TAIL;
  endfunction
  function automatic logic [N-1:0] m_open(input logic [N-1:0] cur, input logic [N-1:0] lk);
    logic [N-1:0] nx = cur;
    for (int i = 0; i < N; i++)
      if (lk[i] && (i == 0 || cur[i-1])) nx[i] = 1'b1;
    return nx;
  endfunction

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      rel <= 0; sys_left <= 0; cpu_left <= HOLD; oe_m <= '0; done_m <= 1'b0;
    end else begin
      rel <= (rel < 3) ? rel + 1 : rel;
      if (m_por(rel)) begin
        sys_left <= 0; cpu_left <= HOLD; oe_m <= '0;
      end else begin
        oe_m <= m_open(oe_m, pll_lock);
        if (wdt_rst_evt || sw_rst_req) sys_left <= SYS;
        else if (sys_left > 0)         sys_left <= sys_left - 1;
        if (sys_left > 0)              cpu_left <= m_cpu_sys(cpu_left);
        else if (cpu_left > 0)         cpu_left <= cpu_left - 1;
      end
      done_m <= (&oe_m) && !m_por(rel) && sys_left == 0
                && !(m_por(rel) || sys_left > 0 || cpu_left > 0);
    end
  end

  always @(posedge clk) if (m_por(rel)) strap_m <= strap_in;

  // ---------------- per-cycle comparison at the falling edge ----------------
  always @(negedge clk) begin
    cycles++;
    if (chk_on) begin
      chk("R1 strap_q",   64'(strap_q), 64'(strap_m));
      chk("R2 pll_rst",   64'(pll_rst), m_por(rel) ? 64'({N{1'b1}}) : 64'd0);
      chk("R2 R3 pll_oe", 64'(pll_oe), 64'(oe_m));
      chk("R4 R7 cpu_rst", 64'(cpu_rst),
          64'(m_por(rel) || sys_left > 0 || cpu_left > 0));
      chk("R5 R6 R10 bus_rst_n", 64'(bus_rst_n), 64'(!(m_por(rel) || sys_left > 0)));
      chk("R8 tmr_clr",   64'(tmr_clr), 64'(rel == 2));
      chk("R9 seq_done",  64'(seq_done), 64'(done_m));
    end
  end

  // Watchdog
  always @(posedge clk) begin
    if (cycles > 150000) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      finish_run();
    end
  end

  // ---------------- stimulus ----------------
  task automatic step();
    @(posedge clk);
    #2;
  endtask

  initial begin
    void'($urandom(32'd20240613));
    por_n = 1'b1; wdt_rst_evt = 1'b0; sw_rst_req = 1'b0;
    pll_lock = '0; strap_in = 8'hA5;
    #1 por_n = 1'b0;
    repeat (3) step();
    chk_on = 1'b1;

    for (int it = 0; it < 24; it++) begin
      int por_len;
      bit dropped;
      por_len = 1 + int'($urandom % 5);
      dropped = 1'b0;
      por_n = 1'b0;
      for (int c = 0; c < por_len; c++) begin
        strap_in = 8'($urandom);
        pll_lock = N'($urandom);            // early locks during power-on (R3)
        wdt_rst_evt = ($urandom % 3 == 0);  // ignored during power-on (R10)
        sw_rst_req  = ($urandom % 4 == 0);
        step();
      end
      por_n = 1'b1;
      wdt_rst_evt = 1'b0; sw_rst_req = 1'b0;
      pll_lock = (it % 3 == 0) ? N'(3'b110) : '0;   // later stages lock first
      for (int c = 0; c < 90 && !dropped; c++) begin
        strap_in = 8'($urandom);                      // must not be captured (R1)
        for (int i = 0; i < N; i++)
          if ($urandom % 6 == 0) pll_lock[i] = 1'b1;
        if (it % 4 == 2 && c == 30) pll_lock = '0;    // enables stay open (R3)
        wdt_rst_evt = (it > 3) && ($urandom % 23 == 0);
        sw_rst_req  = (it > 3) && ($urandom % 29 == 0);
        if (it % 6 == 5 && c == 5) wdt_rst_evt = 1'b1; // overlaps the power-on hold (R7)
        if (it % 5 == 3 && c == 15 + it) begin
          @(posedge clk);
          #2.5 por_n = 1'b0;                          // mid-cycle drop (R11)
          #0.5;
          chk("R11 pll_rst async",   64'(pll_rst),   64'({N{1'b1}}));
          chk("R11 pll_oe async",    64'(pll_oe),    64'd0);
          chk("R11 bus_rst_n async", 64'(bus_rst_n), 64'd0);
          chk("R11 cpu_rst async",   64'(cpu_rst),   64'd1);
          dropped = 1'b1;
        end else begin
          step();
        end
      end
    end

    por_n = 1'b1; wdt_rst_evt = 1'b0; sw_rst_req = 1'b0; pll_lock = '1;
    repeat (HOLD + 10) step();
    chk("R9 final done", 64'(seq_done), 64'd1);
    finish_run();
  end
endmodule